// File: doc/BRIEF.md
# Beamlet Test Pattern Generator

This block produces a continuous stream of complex samples, organised in blocks, for a single beamformer unit. It stands in for real beamlet data in front of a reorder or transpose stage. Every sample says where it came from. The real field holds the sample's beamlet position inside its block. The imaginary field holds the identity of the beamformer unit that emitted it. After reordering, a reader can therefore tell from each output word which input slot fed it.

The stream carries valid, start-of-block, end-of-block and sync flags. Sync marks the first sample of the first block of each interval, and an interval is a fixed number of blocks. Three register-style inputs set the unit identity: polarisation, frequency band and the unit's number inside its band. These are captured at each block boundary. The enable input starts generation. Dropping enable halts it, but only once the current block has finished, and the next start opens a fresh sync interval.

Top module: `beamlet_pattern_gen`

## Requirements
- R1: While a block is in progress, `dv_valid` stays high for exactly 256 consecutive cycles. `dv_sop` is high only on the first of them and `dv_eop` only on the last.
- R2: Bits [7:0] of `dv_data` (the real field) equal the beamlet position within the block, running 0, 1, … 255.
- R3: Bits [15:8] of `dv_data` (the imaginary field) equal the unit code pol*64 + band*4 + local. This gives 0..63 for polarisation 0 and 64..127 for polarisation 1, so bit 15 is always 0.
- R4: The identity inputs are sampled only at a block boundary. A change in the middle of a block leaves the rest of that block unchanged and shows in the next block.
- R5: `dv_sync` is high only together with `dv_sop`. It appears on the first block after a start and then on every 32nd block. The interval length is 16 times the `SYNC_GROUPS` parameter, which is 2 by default.
- R6: While `cfg_enable` stays high, each block's first sample follows the previous block's last sample in the very next cycle, with no gap.
- R7: Lowering `cfg_enable` has no effect on the block in progress. That block finishes, and `dv_valid` then stays low. A low pulse on `cfg_enable` that ends before the block ends causes no break at all.
- R8: When generation restarts after a stop, the first block carries `dv_sync`, whatever the position in the earlier interval was.
- R9: While reset is high and in the first cycle after it, `dv_valid`, `dv_sop`, `dv_eop` and `dv_sync` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Run request; honoured at block boundaries |
| cfg_pol | input | 1 | Polarisation select (0 or 1) |
| cfg_band | input | 4 | Frequency band number, 0..15 |
| cfg_local | input | 2 | Unit number inside its band, 0..3 |
| dv_valid | output | 1 | Sample valid |
| dv_sop | output | 1 | First sample of a block |
| dv_eop | output | 1 | Last sample of a block |
| dv_sync | output | 1 | First sample of a sync interval |
| dv_data | output | 16 | Packed sample {imaginary, real} |

## Verification
The bound checker watches every cycle for the stream's structural properties. It checks that valid holds from start to end of a block and that the real field starts at 0, ends at 255 and steps by one. It also checks that the imaginary field holds steady within a block and matches the identity inputs seen one cycle before the block starts. Sync must coincide with a block start and must appear on every 32nd block and at every restart. Only the directed scenarios can show the timing of a disable relative to a block end. The same holds for a short enable dip being absorbed, an identity change landing in the following block, and the idle period after a stop.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    localparam int FIELD_W        = 8;
    localparam int NUM_BANDS      = 16;
    localparam int UNITS_PER_BAND = 4;
    localparam int BAND_W         = $clog2(NUM_BANDS);
    localparam int LOCAL_W        = $clog2(UNITS_PER_BAND);
    localparam int POL_OFFSET     = NUM_BANDS * UNITS_PER_BAND;
    localparam int DATA_W         = 2 * FIELD_W;

    typedef struct packed {
        logic [FIELD_W-1:0] im;
        logic [FIELD_W-1:0] re;
    } beamlet_t;

    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
        logic sync;
    } strm_ctl_t;

    function automatic logic [FIELD_W-1:0] unit_code(
        input logic               pol,
        input logic [BAND_W-1:0]  band,
        input logic [LOCAL_W-1:0] lu
    );
        int code;
        code = (pol ? POL_OFFSET : 0) + int'(band) * UNITS_PER_BAND + int'(lu);
        return FIELD_W'(code);
    endfunction

endpackage

// File: rtl/bpg_seq.sv
module bpg_seq #(
    parameter int NUM_BEAMLETS    = 256,
    parameter int BLOCKS_PER_SYNC = 32,
    localparam int IDX_W = $clog2(NUM_BEAMLETS),
    localparam int BLK_W = (BLOCKS_PER_SYNC > 1) ? $clog2(BLOCKS_PER_SYNC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic             running,
    output logic [IDX_W-1:0] samp_idx,
    output logic [BLK_W-1:0] blk_idx,
    output logic             blk_start
);

    localparam logic [IDX_W-1:0] LAST_SAMP = IDX_W'(NUM_BEAMLETS - 1);
    localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(BLOCKS_PER_SYNC - 1);

    logic at_last;

    assign at_last   = running && (samp_idx == LAST_SAMP);
    assign blk_start = en && (!running || at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            samp_idx <= '0;
            blk_idx  <= '0;
        end else if (!running) begin
            samp_idx <= '0;
            blk_idx  <= '0;
            running  <= en;
        end else if (at_last) begin
            samp_idx <= '0;
            if (en) begin
                blk_idx <= (blk_idx == LAST_BLK) ? '0 : blk_idx + 1'b1;
            end else begin
                running <= 1'b0;
                blk_idx <= '0;
            end
        end else begin
            samp_idx <= samp_idx + 1'b1;
        end
    end

endmodule

// File: rtl/bpg_id.sv
module bpg_id
    import bpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               pol,
    input  logic [BAND_W-1:0]  band,
    input  logic [LOCAL_W-1:0] lu,
    output logic [FIELD_W-1:0] id_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '0;
        end else if (load) begin
            id_q <= unit_code(pol, band, lu);
        end
    end

endmodule

// File: rtl/bpg_framer.sv
module bpg_framer
    import bpg_pkg::*;
#(
    parameter int NUM_BEAMLETS    = 256,
    parameter int BLOCKS_PER_SYNC = 32,
    localparam int IDX_W = $clog2(NUM_BEAMLETS),
    localparam int BLK_W = (BLOCKS_PER_SYNC > 1) ? $clog2(BLOCKS_PER_SYNC) : 1
) (
    input  logic               running,
    input  logic [IDX_W-1:0]   samp_idx,
    input  logic [BLK_W-1:0]   blk_idx,
    input  logic [FIELD_W-1:0] id_q,
    output strm_ctl_t          ctl,
    output beamlet_t           smp
);

    always_comb begin
        ctl.valid = running;
        ctl.sop   = running && (samp_idx == '0);
        ctl.eop   = running && (samp_idx == IDX_W'(NUM_BEAMLETS - 1));
        ctl.sync  = ctl.sop && (blk_idx == '0);
        smp.im    = id_q;
        smp.re    = FIELD_W'(samp_idx);
    end

endmodule

// File: rtl/beamlet_pattern_gen.sv
module beamlet_pattern_gen
    import bpg_pkg::*;
#(
    parameter int NUM_BEAMLETS  = 256,
    parameter int PRE_TRANSPOSE = 16,
    parameter int SYNC_GROUPS   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_enable,
    input  logic               cfg_pol,
    input  logic [BAND_W-1:0]  cfg_band,
    input  logic [LOCAL_W-1:0] cfg_local,
    output logic               dv_valid,
    output logic               dv_sop,
    output logic               dv_eop,
    output logic               dv_sync,
    output logic [DATA_W-1:0]  dv_data
);

    localparam int BLOCKS_PER_SYNC = PRE_TRANSPOSE * SYNC_GROUPS;
    localparam int IDX_W = $clog2(NUM_BEAMLETS);
    localparam int BLK_W = (BLOCKS_PER_SYNC > 1) ? $clog2(BLOCKS_PER_SYNC) : 1;

    logic               running;
    logic [IDX_W-1:0]   samp_idx;
    logic [BLK_W-1:0]   blk_idx;
    logic               blk_start;
    logic [FIELD_W-1:0] id_q;
    strm_ctl_t          ctl;
    beamlet_t           smp;

    bpg_seq #(
        .NUM_BEAMLETS   (NUM_BEAMLETS),
        .BLOCKS_PER_SYNC(BLOCKS_PER_SYNC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_enable),
        .running  (running),
        .samp_idx (samp_idx),
        .blk_idx  (blk_idx),
        .blk_start(blk_start)
    );

    bpg_id u_id (
        .clk (clk),
        .rst (rst),
        .load(blk_start),
        .pol (cfg_pol),
        .band(cfg_band),
        .lu  (cfg_local),
        .id_q(id_q)
    );

    bpg_framer #(
        .NUM_BEAMLETS   (NUM_BEAMLETS),
        .BLOCKS_PER_SYNC(BLOCKS_PER_SYNC)
    ) u_framer (
        .running (running),
        .samp_idx(samp_idx),
        .blk_idx (blk_idx),
        .id_q    (id_q),
        .ctl     (ctl),
        .smp     (smp)
    );

    assign dv_valid = ctl.valid;
    assign dv_sop   = ctl.sop;
    assign dv_eop   = ctl.eop;
    assign dv_sync  = ctl.sync;
    assign dv_data  = smp;

endmodule

// File: rtl/bpg_checker.sv
module bpg_checker
    import bpg_pkg::*;
#(
    parameter int NUM_BEAMLETS    = 256,
    parameter int BLOCKS_PER_SYNC = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_enable,
    input logic               cfg_pol,
    input logic [BAND_W-1:0]  cfg_band,
    input logic [LOCAL_W-1:0] cfg_local,
    input logic               dv_valid,
    input logic               dv_sop,
    input logic               dv_eop,
    input logic               dv_sync,
    input logic [DATA_W-1:0]  dv_data
);

    logic [FIELD_W-1:0] re_f;
    logic [FIELD_W-1:0] im_f;
    int unsigned        blk_since_sync;

    assign re_f = dv_data[FIELD_W-1:0];
    assign im_f = dv_data[DATA_W-1:FIELD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_since_sync <= 0;
        end else if (dv_sync) begin
            blk_since_sync <= 0;
        end else if (dv_sop) begin
            blk_since_sync <= blk_since_sync + 1;
        end
    end

    assert_valid_holds_R1: assert property (@(posedge clk) disable iff (rst)
        (dv_valid && !dv_eop) |=> dv_valid);

    assert_sop_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
        dv_sop |-> (dv_valid && re_f == '0));

    assert_eop_at_last_R2: assert property (@(posedge clk) disable iff (rst)
        dv_eop |-> (dv_valid && re_f == FIELD_W'(NUM_BEAMLETS - 1)));

    assert_re_steps_R2: assert property (@(posedge clk) disable iff (rst)
        (dv_valid && !dv_eop) |=> (re_f == FIELD_W'($past(re_f) + 1'b1)));

    assert_im_code_R3: assert property (@(posedge clk) disable iff (rst)
        dv_sop |-> (im_f == unit_code($past(cfg_pol), $past(cfg_band), $past(cfg_local))));

    assert_im_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (dv_valid && !dv_eop) |=> $stable(im_f));

    assert_sync_on_sop_R5: assert property (@(posedge clk) disable iff (rst)
        dv_sync |-> dv_sop);

    assert_sync_period_R5: assert property (@(posedge clk) disable iff (rst)
        (dv_sop && blk_since_sync == BLOCKS_PER_SYNC - 1) |-> dv_sync);

    assert_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (dv_eop && cfg_enable) |=> dv_sop);

    assert_stop_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(dv_valid) |-> $past(dv_eop));

    assert_restart_sync_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(dv_valid) |-> dv_sync);

    always_comb begin
        if (rst) begin
            assert_reset_quiet_R9: assert (!(dv_valid || dv_sop || dv_eop || dv_sync) || $time == 0)
                else $error("outputs active during reset");
        end
    end

endmodule

bind beamlet_pattern_gen bpg_checker #(
    .NUM_BEAMLETS   (NUM_BEAMLETS),
    .BLOCKS_PER_SYNC(BLOCKS_PER_SYNC)
) u_chk (.*);

// File: tb/beamlet_pattern_gen_tb.sv
`timescale 1ns/1ps
module beamlet_pattern_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic        cfg_pol = 1'b0;
    logic [3:0]  cfg_band = 4'd0;
    logic [1:0]  cfg_local = 2'd0;
    logic        dv_valid, dv_sop, dv_eop, dv_sync;
    logic [15:0] dv_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    beamlet_pattern_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_enable(cfg_enable),
        .cfg_pol   (cfg_pol),
        .cfg_band  (cfg_band),
        .cfg_local (cfg_local),
        .dv_valid  (dv_valid),
        .dv_sop    (dv_sop),
        .dv_eop    (dv_eop),
        .dv_sync   (dv_sync),
        .dv_data   (dv_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic int code(input int pol, input int band, input int lu);
        return pol * 64 + band * 4 + lu;
    endfunction

    // Checks one full block. On entry the bench sits at a falling edge just
    // before the block (or before an idle stretch if wait_sop is set).
    task automatic check_block(input int exp_im, input bit exp_sync, input bit wait_sop,
                               input int band_at, input int new_band,
                               input int off_at, input int on_at);
        @(negedge clk);
        if (wait_sop) begin
            for (int k = 0; k < 8 && !dv_sop; k++) @(negedge clk);
        end else begin
            chk(dv_sop == 1'b1, "R6 back-to-back sop", int'(dv_sop), 1);
        end
        for (int i = 0; i < 256; i++) begin
            chk(dv_valid == 1'b1, "R1 valid", int'(dv_valid), 1);
            chk(dv_sop == (i == 0), "R1 sop", int'(dv_sop), int'(i == 0));
            chk(dv_eop == (i == 255), "R1 eop", int'(dv_eop), int'(i == 255));
            chk(int'(dv_data[7:0]) == i, "R2 real field", int'(dv_data[7:0]), i);
            chk(int'(dv_data[15:8]) == exp_im, "R3 imag field", int'(dv_data[15:8]), exp_im);
            chk(dv_sync == (exp_sync && i == 0), "R5 sync", int'(dv_sync), int'(exp_sync && i == 0));
            if (i == band_at) cfg_band = 4'(new_band);
            if (i == off_at)  cfg_enable = 1'b0;
            if (i == on_at)   cfg_enable = 1'b1;
            if (i < 255) @(negedge clk);
        end
    endtask

    task automatic check_idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(!(dv_valid || dv_sop || dv_eop || dv_sync), "R7 idle after stop",
                int'({dv_valid, dv_sop, dv_eop, dv_sync}), 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!(dv_valid || dv_sop || dv_eop || dv_sync), "R9 during reset",
            int'({dv_valid, dv_sop, dv_eop, dv_sync}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!(dv_valid || dv_sop || dv_eop || dv_sync), "R9 after reset",
            int'({dv_valid, dv_sop, dv_eop, dv_sync}), 0);
    endtask

    task automatic t_first_and_midchange();
        cfg_pol = 1'b0; cfg_band = 4'd3; cfg_local = 2'd2; cfg_enable = 1'b1;
        check_block(code(0, 3, 2), 1'b1, 1'b1, -1, 0, -1, -1);   // R5 first block syncs
        check_block(code(0, 3, 2), 1'b0, 1'b0, 100, 5, -1, -1);  // R4 change mid-block
        check_block(code(0, 5, 2), 1'b0, 1'b0, -1, 0, -1, -1);   // R4 seen next block
        cfg_pol = 1'b1;
    endtask

    task automatic t_interval();
        for (int b = 3; b < 32; b++) begin
            if (b == 10) check_block(code(1, 5, 2), 1'b0, 1'b0, -1, 0, 10, 20); // R7 short dip
            else         check_block(code(1, 5, 2), 1'b0, 1'b0, -1, 0, -1, -1);
        end
        check_block(code(1, 5, 2), 1'b1, 1'b0, -1, 0, -1, -1);   // R5 32nd block syncs
    endtask

    task automatic t_disable();
        check_block(code(1, 5, 2), 1'b0, 1'b0, -1, 0, 50, -1);   // R7 stop mid-block
        check_idle(20);
    endtask

    task automatic t_reenable();
        cfg_pol = 1'b0; cfg_band = 4'd15; cfg_local = 2'd3; cfg_enable = 1'b1;
        check_block(code(0, 15, 3), 1'b1, 1'b1, -1, 0, -1, -1);  // R8 restart syncs
        check_block(code(0, 15, 3), 1'b0, 1'b0, -1, 0, 255, -1); // stop on last sample
        check_idle(5);
    endtask

    initial begin
        t_reset();
        t_first_and_midchange();
        t_interval();
        t_disable();
        t_reenable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule